// File: doc/BRIEF.md
# Baseband Sleep and Mode Control Register

This block is a single 16-bit control word for a radio baseband controller, reached over a small synchronous bus with a select, a write strobe, write data and combinational read data. Most of its bits are static mode settings that drive control outputs directly: transmit enable, search mode and pattern select, loop gain, bias tracking, hop pulse enable, multiplex mode and fast synthesizer reload after sleep.

Three bits act as commands, and they act on a change in the stored bit rather than on the write strobe. Writing a 1 over a stored 1 does nothing, and neither does writing a 0 over a stored 0. A write that takes the sleep command bit from 0 to 1 puts the block to sleep, but only when the sleep-enable bit in the same write is set. A write that takes either clear bit from 1 to 0 clears the matching status flag. The receive logic sets these flags with one-cycle pulses. A wake pulse ends sleep.

While asleep, the block can hold two derived clocks (codec and processor) high. Each clock has its own enable bit. The hold is applied and released only while the source clock is high, so the output never shows a shortened pulse.

Top module: `sleep_ctl_reg`

## Requirements
- R1: After reset the register reads 0x0000, both status flags are 0, the block is awake and every control output is 0.
- R2: A write with select and strobe high stores all 16 data bits. A read returns the stored word, and this includes bits 5, 4 and 0, which read back as written and not as flag or sleep state.
- R3: The outputs follow the stored bits: bit 15 fast synthesizer reload, bit 12 low loop gain, bit 11 bias tracking, bit 10 transmit enable, bit 9 alternate sync pattern, bit 6 hop enable, bits 2:1 multiplex mode. Bits 8:7 give the search mode (00 off, 01 window, 10 full frame). The stored value 11 is output as 00.
- R4: A one-cycle pulse on acq_set or frm_set sets the matching flag on the next edge, and the flag then holds.
- R5: A write that changes bit 5 from 1 to 0 clears acq_flag. A write that changes bit 4 from 1 to 0 clears frm_flag. Every other write to these bits leaves the flags unchanged.
- R6: If a set pulse and a clearing write arrive in the same cycle, the flag ends up set.
- R7: A write that changes bit 0 from 0 to 1 while bit 3 of the same write data is 1 makes asleep high on the next edge. Writing 1 over a stored 1, or writing with bit 3 at 0, does not change asleep.
- R8: A wake pulse clears asleep on the next edge, and it takes priority over a sleep request in the same cycle.
- R9: While asleep with bit 14 set, codec_clk_o is held high. While asleep with bit 13 set, proc_clk_o is held high. With the bit clear, the output follows its source.
- R10: The hold changes only at an edge where the source is high. While the source is high the output is high, and once the block is awake again the output follows the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not selected |
| acq_set | input | 1 | Pulse that sets the sync-acquired flag |
| frm_set | input | 1 | Pulse that sets the frame-start flag |
| wake | input | 1 | Pulse that ends sleep |
| codec_src | input | 1 | Codec source clock, sampled on clk |
| proc_src | input | 1 | Processor source clock, sampled on clk |
| codec_clk_o | output | 1 | Codec clock, held high in sleep when enabled |
| proc_clk_o | output | 1 | Processor clock, held high in sleep when enabled |
| acq_flag | output | 1 | Sync-acquired status flag |
| frm_flag | output | 1 | Frame-start status flag |
| asleep | output | 1 | Sleep state |
| synth_fast_o | output | 1 | Fast synthesizer reload after sleep |
| bsync_lowgain_o | output | 1 | Reduced bit-sync loop gain |
| bias_en_o | output | 1 | Bias estimation tracking enable |
| tx_en_o | output | 1 | Global transmit enable |
| srch_alt_o | output | 1 | Search for the alternate sync pattern |
| srch_mode_o | output | 2 | Decoded search mode |
| hop_en_o | output | 1 | Hop pulse enable |
| mux_mode_o | output | 2 | Transceiver multiplex mode |

## Verification
The clock-hold properties assume that both source clocks are slow compared with clk, stay stable across each clk edge and hold each level for at least one full clk cycle. The bench steps the sources every two clk cycles, a short time after a rising edge, so that assumption is met. The flag and sleep properties assume that set and wake inputs are single-cycle pulses. The bench drives them only inside one-cycle tasks, at the falling edge.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
    localparam int REG_W   = 16;
    localparam int NCLK    = 2;
    localparam int B_FAST  = 15;
    localparam int B_CHOLD = 14;
    localparam int B_PHOLD = 13;
    localparam int B_GAIN  = 12;
    localparam int B_BIAS  = 11;
    localparam int B_TX    = 10;
    localparam int B_ALT   = 9;
    localparam int B_MODE  = 7;
    localparam int B_HOP   = 6;
    localparam int B_ACLR  = 5;
    localparam int B_FCLR  = 4;
    localparam int B_ARM   = 3;
    localparam int B_MUX   = 1;
    localparam int B_CMD   = 0;

    typedef enum logic [1:0] {
        SRCH_OFF  = 2'b00,
        SRCH_WIN  = 2'b01,
        SRCH_FULL = 2'b10,
        SRCH_RSVD = 2'b11
    } srch_mode_e;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
    } regs_t;

    typedef struct packed {
        logic acq;
        logic frm;
        logic slp;
    } stat_t;
endpackage

// File: rtl/sleep_ctl_regs.sv
module sleep_ctl_regs
    import sleep_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl_q,
    output logic             acq_clr_p,
    output logic             frm_clr_p,
    output logic             slp_req_p
);
    regs_t r_d, r_q;
    logic  wr_en;

    always_comb begin
        wr_en     = sel & wr;
        r_d       = r_q;
        if (wr_en) r_d.ctl = wdata;
        // commands act on stored-bit transitions only
        acq_clr_p = wr_en &  r_q.ctl[B_ACLR] & ~wdata[B_ACLR];
        frm_clr_p = wr_en &  r_q.ctl[B_FCLR] & ~wdata[B_FCLR];
        slp_req_p = wr_en & ~r_q.ctl[B_CMD]  &  wdata[B_CMD] & wdata[B_ARM];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl_q = r_q.ctl;
endmodule

// File: rtl/sleep_ctl_state.sv
module sleep_ctl_state
    import sleep_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_set,
    input  logic frm_set,
    input  logic acq_clr,
    input  logic frm_clr,
    input  logic slp_req,
    input  logic wake,
    output logic acq_flag,
    output logic frm_flag,
    output logic asleep
);
    stat_t s_d, s_q;

    always_comb begin
        s_d.acq = acq_set | (s_q.acq & ~acq_clr);
        s_d.frm = frm_set | (s_q.frm & ~frm_clr);
        if (wake)         s_d.slp = 1'b0;
        else if (slp_req) s_d.slp = 1'b1;
        else              s_d.slp = s_q.slp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acq_flag = s_q.acq;
    assign frm_flag = s_q.frm;
    assign asleep   = s_q.slp;
endmodule

// File: rtl/sleep_ctl_clkhold.sv
module sleep_ctl_clkhold #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] hold_req,
    output logic [N-1:0] clk_out
);
    logic [N-1:0] gate_d, gate_q;

    for (genvar i = 0; i < N; i++) begin : g_hold
        // the hold may only change while the source sits high
        always_comb gate_d[i] = src[i] ? hold_req[i] : gate_q[i];
        assign clk_out[i] = src[i] | gate_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/sleep_ctl_reg.sv
module sleep_ctl_reg
    import sleep_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        acq_set,
    input  logic        frm_set,
    input  logic        wake,
    input  logic        codec_src,
    input  logic        proc_src,
    output logic        codec_clk_o,
    output logic        proc_clk_o,
    output logic        acq_flag,
    output logic        frm_flag,
    output logic        asleep,
    output logic        synth_fast_o,
    output logic        bsync_lowgain_o,
    output logic        bias_en_o,
    output logic        tx_en_o,
    output logic        srch_alt_o,
    output logic [1:0]  srch_mode_o,
    output logic        hop_en_o,
    output logic [1:0]  mux_mode_o
);
    logic [REG_W-1:0] ctl;
    logic             acq_clr_p, frm_clr_p, slp_req_p;
    logic             codec_hold, proc_hold;
    logic [NCLK-1:0]  clk_src, clk_hold, clk_out;
    srch_mode_e       mode_raw;

    sleep_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr        (wr),
        .wdata     (wdata),
        .ctl_q     (ctl),
        .acq_clr_p (acq_clr_p),
        .frm_clr_p (frm_clr_p),
        .slp_req_p (slp_req_p)
    );

    sleep_ctl_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_set  (acq_set),
        .frm_set  (frm_set),
        .acq_clr  (acq_clr_p),
        .frm_clr  (frm_clr_p),
        .slp_req  (slp_req_p),
        .wake     (wake),
        .acq_flag (acq_flag),
        .frm_flag (frm_flag),
        .asleep   (asleep)
    );

    assign codec_hold = ctl[B_CHOLD];
    assign proc_hold  = ctl[B_PHOLD];
    assign clk_src    = {proc_src, codec_src};
    assign clk_hold   = {asleep & proc_hold, asleep & codec_hold};

    sleep_ctl_clkhold #(.N(NCLK)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (clk_src),
        .hold_req (clk_hold),
        .clk_out  (clk_out)
    );

    assign codec_clk_o = clk_out[0];
    assign proc_clk_o  = clk_out[1];

    always_comb begin
        mode_raw        = srch_mode_e'(ctl[B_MODE +: 2]);
        srch_mode_o     = (mode_raw == SRCH_RSVD) ? SRCH_OFF : mode_raw;
        rdata           = sel ? ctl : '0;
        synth_fast_o    = ctl[B_FAST];
        bsync_lowgain_o = ctl[B_GAIN];
        bias_en_o       = ctl[B_BIAS];
        tx_en_o         = ctl[B_TX];
        srch_alt_o      = ctl[B_ALT];
        hop_en_o        = ctl[B_HOP];
        mux_mode_o      = ctl[B_MUX +: 2];
    end
endmodule

// File: rtl/sleep_ctl_reg_chk.sv
module sleep_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr,
    input logic [15:0] wdata,
    input logic        acq_set,
    input logic        frm_set,
    input logic        wake,
    input logic        asleep,
    input logic        acq_flag,
    input logic        frm_flag,
    input logic [1:0]  srch_mode_o,
    input logic        codec_src,
    input logic        codec_clk_o,
    input logic        proc_src,
    input logic        proc_clk_o,
    input logic        codec_hold,
    input logic        proc_hold
);
    a_r3_mode_never_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        srch_mode_o != 2'b11);
    a_r4_acq_set: assert property (@(posedge clk) disable iff (!rst_n)
        acq_set |=> acq_flag);
    a_r6_frm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        frm_set |=> frm_flag);
    a_r7_unarmed_stays_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !wdata[3] && !asleep) |=> !asleep);
    a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !asleep);
    a_r9_codec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && codec_hold && codec_src) |=> codec_clk_o);
    a_r9_proc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && proc_hold && proc_src) |=> proc_clk_o);
    a_r10_codec_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && codec_src) |=> (codec_clk_o == codec_src));
    a_r10_proc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && proc_src) |=> (proc_clk_o == proc_src));
endmodule

bind sleep_ctl_reg sleep_ctl_reg_chk u_chk (.*);

// File: tb/sleep_ctl_reg_test.sv
`timescale 1ns/1ps
module sleep_ctl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        acq_set = 1'b0, frm_set = 1'b0, wake = 1'b0;
    logic [3:0]  div = '0;
    logic        codec_src, proc_src;
    logic        codec_clk_o, proc_clk_o, acq_flag, frm_flag, asleep;
    logic        synth_fast_o, bsync_lowgain_o, bias_en_o, tx_en_o, srch_alt_o, hop_en_o;
    logic [1:0]  srch_mode_o, mux_mode_o;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) begin
        #1;
        div <= div + 4'd1;
    end
    assign codec_src = div[1];
    assign proc_src  = ~div[1];

    sleep_ctl_reg uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [15:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] exp);
        sel = 1'b1;
        #0.5;
        check(req, rdata, exp);
        sel = 1'b0;
    endtask

    function automatic logic [9:0] outs_exp(input logic [15:0] v);
        logic [1:0] m;
        m = v[8:7];
        if (m == 2'b11) m = 2'b00;
        return {v[15], v[12], v[11], v[10], v[9], m, v[6], v[2:1]};
    endfunction

    function automatic logic [9:0] outs_act();
        return {synth_fast_o, bsync_lowgain_o, bias_en_o, tx_en_o, srch_alt_o,
                srch_mode_o, hop_en_o, mux_mode_o};
    endfunction

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_check("R1 rdata", 16'h0000);
        check("R1 flags/sleep", {acq_flag, frm_flag, asleep}, 3'b000);
        check("R1 outputs", outs_act(), 10'd0);

        // R2/R3 walking one through every bit
        for (int b = 0; b < 16; b++) begin
            logic [15:0] v;
            v = 16'h1 << b;
            write(v);
            read_check("R2 walk readback", v);
            check("R3 walk outputs", outs_act(), outs_exp(v));
            check("R7 single bit no sleep", asleep, 1'b0);
        end
        write(16'h0000);

        // R3 search mode sweep including the unused code
        for (int m = 0; m < 4; m++) begin
            logic [15:0] v;
            v = 16'(m) << 7;
            write(v);
            check("R3 search mode", srch_mode_o, (m == 3) ? 2'b00 : 2'(m));
            read_check("R2 mode readback", v);
        end

        // R4/R5 transition sweep on both clear bits
        for (int k = 0; k < 2; k++) begin
            for (int o = 0; o < 2; o++) begin
                for (int n = 0; n < 2; n++) begin
                    int bp;
                    bp = (k == 0) ? 5 : 4;
                    write(16'(o) << bp);
                    @(negedge clk);
                    if (k == 0) acq_set = 1'b1; else frm_set = 1'b1;
                    @(negedge clk);
                    acq_set = 1'b0; frm_set = 1'b0;
                    check("R4 flag set", (k == 0) ? acq_flag : frm_flag, 1'b1);
                    write(16'(n) << bp);
                    check("R5 clear on 1->0 only", (k == 0) ? acq_flag : frm_flag,
                          (o == 1 && n == 0) ? 1'b0 : 1'b1);
                    read_check("R2 clear bit readback", 16'(n) << bp);
                end
            end
        end

        // R6 set wins over a simultaneous clearing write
        write(16'h0030);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; wdata = 16'h0000; acq_set = 1'b1; frm_set = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; acq_set = 1'b0; frm_set = 1'b0;
        check("R6 set wins", {acq_flag, frm_flag}, 2'b11);
        write(16'h0030);
        write(16'h0000);
        check("R5 clear after R6", {acq_flag, frm_flag}, 2'b00);

        // R7 sleep command sweep: previous bit0, new bit0, enable bit3
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 2; n++) begin
                for (int a = 0; a < 2; a++) begin
                    logic [15:0] v;
                    write(16'(p));
                    v = 16'(n) | (16'(a) << 3);
                    write(v);
                    check("R7 sleep entry", asleep, (p == 0 && n == 1 && a == 1) ? 1'b1 : 1'b0);
                    read_check("R2 cmd readback", v);
                    pulse_wake();
                    check("R8 wake", asleep, 1'b0);
                end
            end
        end

        // R8 wake beats a sleep request in the same cycle
        write(16'h0000);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; wdata = 16'h0009; wake = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wake = 1'b0;
        check("R8 wake priority", asleep, 1'b0);

        // R9/R10 clock hold sweep
        for (int h = 0; h < 4; h++) begin
            logic hc, hp;
            hc = h[0]; hp = h[1];
            write(16'h0000);
            write({1'b0, hc, hp, 9'd0, 4'b1001});
            check("R9 asleep", asleep, 1'b1);
            repeat (6) @(negedge clk);
            for (int s = 0; s < 8; s++) begin
                check("R9 codec out", codec_clk_o, codec_src | hc);
                check("R9 proc out", proc_clk_o, proc_src | hp);
                @(negedge clk);
            end
            pulse_wake();
            repeat (6) @(negedge clk);
            for (int s = 0; s < 8; s++) begin
                check("R10 codec resumes", codec_clk_o, codec_src);
                check("R10 proc resumes", proc_clk_o, proc_src);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule